// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block decides, from the interrupt state of a hart, whether an interrupt must be taken now and which cause number to take. It takes the raw pending vector and the per-cause enable vector, and treats as a candidate any cause that is both pending and enabled. A delegation vector then sorts each candidate into one of two groups. A candidate with its delegation bit clear is handled at machine level. A candidate with its delegation bit set is handled at supervisor level.

Each group is let through or blocked by a gate. The gate opens according to the current privilege level and the matching global enable bit. Candidates that pass either gate are merged, and the lowest-numbered one wins. The result can leave the block straight from the logic, or one clock later from a register stage. The register stage is chosen by a parameter.

The block feeds the trap-entry logic of a core. That logic samples the take flag and, while it is high, uses the cause index.

Top module: `irq_pend_sel`

## Requirements
- R1: A cause is a candidate only when both its pending bit and its enable bit are 1. A cause whose enable bit is 0 is never selected, whatever its pending bit.
- R2: Privilege is encoded U=0, S=1, M=3. The machine-level gate is open whenever privilege is U or S. At privilege M it is open only while the machine global enable input is 1.
- R3: The supervisor-level gate is open whenever privilege is U. At privilege S it is open only while the supervisor global enable input is 1. At privilege M it is closed.
- R4: A candidate with delegation bit 0 passes only through the machine-level gate. A candidate with delegation bit 1 passes only through the supervisor-level gate. The candidates that pass either gate are ORed together.
- R5: When at least one candidate passes, the take flag is 1 and the cause output equals the index of the lowest-numbered passing bit. Bit 0 has the highest priority.
- R6: When no candidate passes, the take flag is 0 and the cause output is 0.
- R7: The reserved privilege value 2 opens neither gate, so the take flag is 0.
- R8: With the default registered output, both outputs reflect the inputs present at the previous rising clock edge and hold until the next edge. While the active-low reset is asserted, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| pend_i | input | NUM_IRQ (32) | Interrupt pending vector |
| en_i | input | NUM_IRQ (32) | Per-cause interrupt enable vector |
| deleg_i | input | NUM_IRQ (32) | Delegation vector, 1 = supervisor-handled |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M, 2 reserved |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | $clog2(NUM_IRQ) (5) | Selected cause index, 0 when take_o is 0 |

## Verification
The hardest case to reach from the ports is a lower-numbered candidate that is blocked by its gate while a higher-numbered one in the other group passes. Here the winner is not simply the lowest pending and enabled bit. Finding it depends on the delegation bit and the privilege rules together.

The stimulus sets mixed delegation patterns so that neighbouring causes fall into different groups. It sweeps each single cause together with a fixed high-numbered competitor across every privilege value and every pair of global enables. Random vectors are then compared against an independent scan-based model computed in the bench.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'd0,
      PRIV_SUPER = 2'd1,
      PRIV_RSVD  = 2'd2,
      PRIV_MACH  = 2'd3
   } priv_e;

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
   import irqsel_pkg::*;
(
   input  logic [1:0] priv_i,
   input  logic       mie_i,
   input  logic       sie_i,
   output logic       m_open_o,
   output logic       s_open_o
);

   always_comb begin
      m_open_o = 1'b0;
      s_open_o = 1'b0;
      case (priv_e'(priv_i))
         PRIV_USER: begin
            m_open_o = 1'b1;
            s_open_o = 1'b1;
         end
         PRIV_SUPER: begin
            m_open_o = 1'b1;
            s_open_o = sie_i;
         end
         PRIV_MACH: begin
            m_open_o = mie_i;
            s_open_o = 1'b0;
         end
         default: begin
            m_open_o = 1'b0;
            s_open_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/irqsel_ffs.sv
module irqsel_ffs #(
   parameter int W  = 32,
   localparam int CW = $clog2(W),
   localparam int L  = $clog2(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic          any_o,
   output logic [CW-1:0] idx_o
);

   if ((1 << L) != W || W < 2) begin : g_bad_width
      $error("irqsel_ffs: W must be a power of two of at least 2");
   end

   for (genvar k = 0; k <= L; k++) begin : lvl
      localparam int NK = W >> k;
      logic [NK-1:0] vld;
      logic [CW-1:0] idx [NK];
      if (k == 0) begin : g_leaf
         assign vld = vec_i;
         for (genvar j = 0; j < NK; j++) begin : g_n
            assign idx[j] = CW'(j);
         end
      end else begin : g_node
         for (genvar j = 0; j < NK; j++) begin : g_n
            assign vld[j] = lvl[k-1].vld[2*j] | lvl[k-1].vld[2*j+1];
            assign idx[j] = lvl[k-1].vld[2*j] ? lvl[k-1].idx[2*j]
                                              : lvl[k-1].idx[2*j+1];
         end
      end
   end

   assign any_o = lvl[L].vld[0];
   assign idx_o = lvl[L].vld[0] ? lvl[L].idx[0] : '0;

endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel #(
   parameter int NUM_IRQ = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int CW = $clog2(NUM_IRQ)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_IRQ-1:0] pend_i,
   input  logic [NUM_IRQ-1:0] en_i,
   input  logic [NUM_IRQ-1:0] deleg_i,
   input  logic [1:0]         priv_i,
   input  logic               mie_i,
   input  logic               sie_i,
   output logic               take_o,
   output logic [CW-1:0]      cause_o
);

   if (NUM_IRQ < 2 || NUM_IRQ > 64) begin : g_bad_num
      $error("irq_pend_sel: NUM_IRQ must lie between 2 and 64");
   end

   logic               m_open;
   logic               s_open;
   logic [NUM_IRQ-1:0] cand;
   logic [NUM_IRQ-1:0] passed;
   logic               take_c;
   logic [CW-1:0]      cause_c;

   irqsel_gate u_gate (
      .priv_i   (priv_i),
      .mie_i    (mie_i),
      .sie_i    (sie_i),
      .m_open_o (m_open),
      .s_open_o (s_open)
   );

   assign cand   = pend_i & en_i;
   assign passed = (cand & ~deleg_i & {NUM_IRQ{m_open}})
                 | (cand &  deleg_i & {NUM_IRQ{s_open}});

   irqsel_ffs #(.W(NUM_IRQ)) u_ffs (
      .vec_i (passed),
      .any_o (take_c),
      .idx_o (cause_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            take_o  <= 1'b0;
            cause_o <= '0;
         end else begin
            take_o  <= take_c;
            cause_o <= cause_c;
         end
      end
   end else begin : g_comb
      assign take_o  = take_c;
      assign cause_o = cause_c;
   end

endmodule

// File: rtl/irq_pend_sel_chk.sv
module irq_pend_sel_chk #(
   parameter int NUM_IRQ = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int CW = $clog2(NUM_IRQ)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_IRQ-1:0] pend_i,
   input logic [NUM_IRQ-1:0] en_i,
   input logic [NUM_IRQ-1:0] deleg_i,
   input logic [1:0]         priv_i,
   input logic               mie_i,
   input logic               sie_i,
   input logic               take_o,
   input logic [CW-1:0]      cause_o
);

   localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

   logic               d_vld;
   logic [NUM_IRQ-1:0] d_pend;
   logic [NUM_IRQ-1:0] d_en;
   logic [NUM_IRQ-1:0] d_deleg;
   logic [1:0]         d_priv;
   logic               d_mie;
   logic [NUM_IRQ-1:0] low_mask;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            d_vld   <= 1'b0;
            d_pend  <= '0;
            d_en    <= '0;
            d_deleg <= '0;
            d_priv  <= 2'd0;
            d_mie   <= 1'b0;
         end else begin
            d_vld   <= 1'b1;
            d_pend  <= pend_i;
            d_en    <= en_i;
            d_deleg <= deleg_i;
            d_priv  <= priv_i;
            d_mie   <= mie_i;
         end
      end
   end else begin : g_now
      assign d_vld   = 1'b1;
      assign d_pend  = pend_i;
      assign d_en    = en_i;
      assign d_deleg = deleg_i;
      assign d_priv  = priv_i;
      assign d_mie   = mie_i;
   end

   assign low_mask = (ONE << cause_o) - ONE;

   assert_cand_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (d_vld && take_o) |-> (d_pend[cause_o] && d_en[cause_o]));

   assert_mach_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (d_vld && d_priv == 2'd3 && !d_mie) |-> !take_o);

   assert_mach_no_deleg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (d_vld && d_priv == 2'd3 && take_o) |-> !d_deleg[cause_o]);

   assert_lowest_user_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (d_vld && d_priv == 2'd0 && take_o) |-> ((d_pend & d_en & low_mask) == '0));

   assert_idle_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_o |-> (cause_o == '0));

   assert_rsvd_priv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (d_vld && d_priv == 2'd2) |-> !take_o);

   assert_first_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !d_vld |-> (!take_o && cause_o == '0));

   logic unused_ok;
   assign unused_ok = sie_i;

endmodule

bind irq_pend_sel irq_pend_sel_chk #(.NUM_IRQ(NUM_IRQ), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/irq_pend_sel_tb_top.sv
`timescale 1ns/1ps
module irq_pend_sel_tb_top;

   localparam int N  = 32;
   localparam int CW = 5;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic [N-1:0]  pend_i = '0;
   logic [N-1:0]  en_i = '0;
   logic [N-1:0]  deleg_i = '0;
   logic [1:0]    priv_i = 2'd0;
   logic          mie_i = 1'b0;
   logic          sie_i = 1'b0;
   logic          take_o;
   logic [CW-1:0] cause_o;

   int checks = 0;
   int failures = 0;
   logic          prev_take = 1'b0;
   logic [CW-1:0] prev_cause = '0;

   always #2 clk_i = ~clk_i;

   irq_pend_sel #(.NUM_IRQ(N), .REG_OUT(1'b1)) dut_i (.*);

   function automatic logic [CW:0] model(input logic [N-1:0] p, input logic [N-1:0] e,
                                         input logic [N-1:0] d, input logic [1:0] pr,
                                         input logic mi, input logic si);
      logic mg, sg;
      mg = (pr == 2'd0) || (pr == 2'd1) || (pr == 2'd3 && mi);
      sg = (pr == 2'd0) || (pr == 2'd1 && si);
      for (int i = 0; i < N; i++) begin
         if (p[i] && e[i] && (d[i] ? sg : mg)) return {1'b1, CW'(i)};
      end
      return '0;
   endfunction

   task automatic check(input string tag, input logic et, input logic [CW-1:0] ec);
      checks++;
      if (take_o !== et || cause_o !== ec) begin
         failures++;
         $display("FAIL %s take=%0d cause=%0d expected take=%0d cause=%0d",
                  tag, take_o, cause_o, et, ec);
      end
   endtask

   task automatic apply(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] d, input logic [1:0] pr,
                        input logic mi, input logic si);
      logic [CW:0] exp;
      pend_i = p; en_i = e; deleg_i = d; priv_i = pr; mie_i = mi; sie_i = si;
      #1;
      check({tag, " R8 hold"}, prev_take, prev_cause);
      @(negedge clk_i);
      exp = model(p, e, d, pr, mi, si);
      check(tag, exp[CW], exp[CW-1:0]);
      prev_take = exp[CW];
      prev_cause = exp[CW-1:0];
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      pend_i = '1; en_i = '1;
      repeat (3) @(negedge clk_i);
      check("R8 reset", 1'b0, '0);
      rst_ni = 1'b1;
      pend_i = '0; en_i = '0;
      @(negedge clk_i);

      apply("R1 enables off", '1, '0, '0, 2'd0, 1'b1, 1'b1);
      apply("R1 pend off", '0, '1, '0, 2'd0, 1'b1, 1'b1);
      apply("R2 M mie0", 32'h80, 32'h80, '0, 2'd3, 1'b0, 1'b1);
      apply("R2 M mie1", 32'h80, 32'h80, '0, 2'd3, 1'b1, 1'b0);
      apply("R2 S mie0", 32'h80, 32'h80, '0, 2'd1, 1'b0, 1'b0);
      apply("R3 S sie0", 32'h20, 32'h20, 32'h20, 2'd1, 1'b1, 1'b0);
      apply("R3 S sie1", 32'h20, 32'h20, 32'h20, 2'd1, 1'b0, 1'b1);
      apply("R3 U sie0", 32'h20, 32'h20, 32'h20, 2'd0, 1'b0, 1'b0);
      apply("R3 M closed", 32'h20, 32'h20, 32'h20, 2'd3, 1'b1, 1'b1);
      apply("R4 M mixed", 32'h208, '1, 32'h8, 2'd3, 1'b1, 1'b1);
      apply("R4 S mixed", 32'h208, '1, 32'h8, 2'd1, 1'b0, 1'b0);
      apply("R4 S deleg wins", 32'h208, '1, 32'h8, 2'd1, 1'b0, 1'b1);
      apply("R5 both ends", 32'h80000001, '1, '0, 2'd0, 1'b0, 1'b0);
      apply("R5 top only", 32'h80000000, '1, '0, 2'd0, 1'b0, 1'b0);
      apply("R6 none", '0, '0, '0, 2'd3, 1'b1, 1'b1);
      apply("R7 reserved", '1, '1, 32'h5555AAAA, 2'd2, 1'b1, 1'b1);

      for (int pr = 0; pr < 4; pr++) begin
         for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < N; i++) begin
               apply("R5 sweep", (N'(1) << i) | 32'h80000000, '1, 32'hAAAA5555,
                     2'(pr), g[0], g[1]);
            end
         end
      end

      for (int r = 0; r < 3000; r++) begin
         apply("R4 random", $urandom, $urandom, $urandom, 2'($urandom), 1'($urandom),
               1'($urandom));
      end

      rst_ni = 1'b0;
      #1;
      check("R8 reset again", 1'b0, '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule